// File: doc/BRIEF.md
# UART Modem-Line Control and Input-Change Interrupt

This block sits beside a UART's data path and owns its modem handshake lines. Software writes a modem-control register to set the data-terminal-ready and request-to-send lines and to turn on internal loopback. Each of those two output pins carries the complement of the bit that was written. In loopback the transmit serial stream is fed straight into the receiver and the outgoing line is held at idle.

The four incoming modem lines (clear-to-send, carrier-detect, ring and data-set-ready) pass through two-flop synchronisers. Their levels can be read from an external-input register. A change on clear-to-send or carrier-detect can set a sticky change flag. Each of these two lines has its own mask bit and its own any-edge bit: with the any-edge bit set, either direction counts; with it clear, only a rising edge counts. Reading the external-input register returns the flags and clears them in the same access. The OR of the two flags, gated by an enable that comes from the main UART interrupt register, forms one interrupt output.

Top module: `modem_line_ctrl`

## Requirements
- R1: After reset, the modem-control bits and external-input configuration bits are 0. Both handshake pins are 1, loopback is off, both change flags are clear and `extIrq` is 0.
- R2: A write to address 0 stores the data-terminal-ready bit from wdata[0] and the request-to-send bit from wdata[1]. From the next cycle, `dtrOut` equals the inverse of the first bit and `rtsOut` the inverse of the second.
- R3: Address 0 reads back {loop, rts, dtr} in bits [2:0]. Address 1 reads back its configuration in bits [3:0] in this order: cts mask, dcd mask, cts any-edge, dcd any-edge. All are written through the same address.
- R4: Address 1 bits [7:4] return the synchronised levels of cts, dcd, ri and dsr, in that bit order, two clock edges after an input changes.
- R5: When a line's mask and any-edge bits are both set, an edge in either direction sets its change flag. The cts flag is read at bit 8 and the dcd flag at bit 9 of address 1, and the flag is set on the third clock edge after the input changes.
- R6: When a line's mask is set and its any-edge bit is clear, only a rising edge sets its flag; a falling edge leaves it clear.
- R7: When a line's mask bit is clear, no edge on that line sets its flag.
- R8: A read of address 1 returns the flags as they stood before that access and clears them on the same clock edge.
- R9: If a flag-setting edge is detected on the same clock edge as a clearing read, the flag ends up set.
- R10: `extIrq` is 1 exactly when `extIrqEn` is 1 and at least one change flag is set, with no added delay from either.
- R11: With loopback (address 0, wdata[2]) on, `rxSerOut` follows `txSerIn` and `txSerOut` is held at 1. With loopback off, `txSerOut` follows `txSerIn` and `rxSerOut` follows `rxSerIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (clears flags at address 1) |
| busAddr | input | 1 | 0 = modem control, 1 = external input |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from busAddr |
| ctsIn | input | 1 | Clear-to-send line, asynchronous |
| dcdIn | input | 1 | Carrier-detect line, asynchronous |
| riIn | input | 1 | Ring line, asynchronous |
| dsrIn | input | 1 | Data-set-ready line, asynchronous |
| dtrOut | output | 1 | Data-terminal-ready pin, inverse of written bit |
| rtsOut | output | 1 | Request-to-send pin, inverse of written bit |
| extIrqEn | input | 1 | Enable from the main interrupt register |
| extIrq | output | 1 | Combined input-change interrupt |
| txSerIn | input | 1 | Serial stream from the transmitter |
| rxSerIn | input | 1 | Serial line from the pad |
| txSerOut | output | 1 | Serial line to the pad |
| rxSerOut | output | 1 | Serial stream to the receiver |

## Verification
Each result has its own latency. The handshake pins and readback are due one edge after a write. Input levels are due after two edges of synchronisation. Change flags are due after three edges, one more for the previous-value register. The interrupt, read data and loopback mux are combinational and are due in the same cycle. The bench changes inputs on the falling edge, waits exactly that many rising edges and samples on a falling edge. The tests of the edge-and-read collision start the read after two edges, so that the clear and the flag set land on the same edge.

// File: rtl/modem_line_pkg.sv
package modem_line_pkg;
  localparam int ADDR_MODEM = 0;
  localparam int ADDR_EXTIN = 1;
  // modem-control bit positions
  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_LOOP = 2;
  // external-input configuration bit positions
  localparam int EI_CFG_W = 4;
  localparam int EI_LVL_LO = 4;
  localparam int EI_CHG_LO = 8;
  localparam int MDM_LINES = 4;  // cts, dcd, ri, dsr
  localparam int LINE_CTS = 0;
  localparam int LINE_DCD = 1;

  typedef struct packed {
    logic wrModem;
    logic wrExtIn;
    logic rdExtIn;
  } regStrobe_t;
endpackage

// File: rtl/mlc_sync.sv
module mlc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= asyncIn;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/mlc_decode.sv
module mlc_decode
  import modem_line_pkg::*;
(
  input  logic       busWr,
  input  logic       busRd,
  input  logic       busAddr,
  output regStrobe_t strb
);
  always_comb begin
    strb.wrModem = busWr && (busAddr == 1'(ADDR_MODEM));
    strb.wrExtIn = busWr && (busAddr == 1'(ADDR_EXTIN));
    strb.rdExtIn = busRd && (busAddr == 1'(ADDR_EXTIN));
  end
endmodule

// File: rtl/mlc_datapath.sv
module mlc_datapath
  import modem_line_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strb,
  input  logic                 busAddr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [MDM_LINES-1:0] lineLvl,
  input  logic                 extIrqEn,
  input  logic                 txSerIn,
  input  logic                 rxSerIn,
  output logic [DATA_W-1:0]    rdata,
  output logic                 dtrOut,
  output logic                 rtsOut,
  output logic                 txSerOut,
  output logic                 rxSerOut,
  output logic                 extIrq
);
  logic dtrBit, rtsBit, loopBit;
  logic [1:0] chgMask, anyEdge, chgFlag, lvlPrev, chgSet;

  logic unusedBits;
  assign unusedBits = ^wdata[DATA_W-1:EI_CFG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dtrBit <= 1'b0; rtsBit <= 1'b0; loopBit <= 1'b0;
    end else if (strb.wrModem) begin
      dtrBit  <= wdata[MC_DTR];
      rtsBit  <= wdata[MC_RTS];
      loopBit <= wdata[MC_LOOP];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chgMask <= '0; anyEdge <= '0;
    end else if (strb.wrExtIn) begin
      chgMask <= wdata[1:0];
      anyEdge <= wdata[3:2];
    end
  end

  // edge detection and sticky flags for cts (0) and dcd (1)
  for (genvar i = 0; i < 2; i++) begin : g_chg
    logic rise, fall;
    assign rise = lineLvl[i] && !lvlPrev[i];
    assign fall = !lineLvl[i] && lvlPrev[i];
    assign chgSet[i] = chgMask[i] && (rise || (anyEdge[i] && fall));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lvlPrev[i] <= 1'b0;
        chgFlag[i] <= 1'b0;
      end else begin
        lvlPrev[i] <= lineLvl[i];
        if (chgSet[i])          chgFlag[i] <= 1'b1;
        else if (strb.rdExtIn)  chgFlag[i] <= 1'b0;
      end
    end

    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      (strb.rdExtIn && chgSet[i]) |=> chgFlag[i]);
    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      (strb.rdExtIn && !chgSet[i]) |=> !chgFlag[i]);
    p_masked_r7: assert property (@(posedge clk) disable iff (!rstN)
      (!chgMask[i] && !chgFlag[i]) |=> !chgFlag[i]);
  end

  always_comb begin
    rdata = '0;
    if (busAddr == 1'(ADDR_MODEM)) begin
      rdata[MC_DTR]  = dtrBit;
      rdata[MC_RTS]  = rtsBit;
      rdata[MC_LOOP] = loopBit;
    end else begin
      rdata[1:0] = chgMask;
      rdata[3:2] = anyEdge;
      rdata[EI_LVL_LO +: MDM_LINES] = lineLvl;
      rdata[EI_CHG_LO +: 2] = chgFlag;
    end
  end

  assign dtrOut   = ~dtrBit;
  assign rtsOut   = ~rtsBit;
  assign txSerOut = loopBit ? 1'b1 : txSerIn;
  assign rxSerOut = loopBit ? txSerIn : rxSerIn;
  assign extIrq   = extIrqEn && (|chgFlag);

  p_pin_inv_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrModem |=> (dtrOut == !$past(wdata[MC_DTR])) && (rtsOut == !$past(wdata[MC_RTS])));
  p_loop_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    loopBit |-> (txSerOut && (rxSerOut == txSerIn)));
endmodule

// File: rtl/modem_line_ctrl.sv
module modem_line_ctrl
  import modem_line_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              ctsIn,
  input  logic              dcdIn,
  input  logic              riIn,
  input  logic              dsrIn,
  output logic              dtrOut,
  output logic              rtsOut,
  input  logic              extIrqEn,
  output logic              extIrq,
  input  logic              txSerIn,
  input  logic              rxSerIn,
  output logic              txSerOut,
  output logic              rxSerOut
);
  regStrobe_t strb;
  logic [MDM_LINES-1:0] lineLvl;

  mlc_decode u_decode (
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .strb(strb)
  );

  mlc_sync #(.WIDTH(MDM_LINES), .STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({dsrIn, riIn, dcdIn, ctsIn}),
    .syncOut(lineLvl)
  );

  mlc_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .wdata(busWdata), .lineLvl(lineLvl), .extIrqEn(extIrqEn),
    .txSerIn(txSerIn), .rxSerIn(rxSerIn), .rdata(busRdata),
    .dtrOut(dtrOut), .rtsOut(rtsOut), .txSerOut(txSerOut),
    .rxSerOut(rxSerOut), .extIrq(extIrq)
  );

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    extIrq |-> extIrqEn);
  p_reset_pins_r1: assert property (@(posedge clk)
    !rstN |=> (dtrOut && rtsOut && !extIrq));
endmodule

// File: tb/modem_line_ctrl_bench.sv
module modem_line_ctrl_bench;
  localparam int DW = 16;
  logic clk = 1'b0, rstN = 1'b0;
  logic busWr = 0, busRd = 0, busAddr = 0;
  logic [DW-1:0] busWdata = '0, busRdata;
  logic ctsIn = 0, dcdIn = 0, riIn = 0, dsrIn = 0;
  logic dtrOut, rtsOut, extIrq, txSerOut, rxSerOut;
  logic extIrqEn = 0, txSerIn = 1, rxSerIn = 1;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modem_line_ctrl u_modem_line_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .ctsIn(ctsIn), .dcdIn(dcdIn),
    .riIn(riIn), .dsrIn(dsrIn), .dtrOut(dtrOut), .rtsOut(rtsOut),
    .extIrqEn(extIrqEn), .extIrq(extIrq), .txSerIn(txSerIn), .rxSerIn(rxSerIn),
    .txSerOut(txSerOut), .rxSerOut(rxSerOut)
  );

  // {dtrW, rtsW, loopW, txIn, rxIn, expDtr, expRts, expTx, expRx}
  localparam logic [8:0] VEC [6] = '{
    9'b000_10_1110, 9'b100_01_0101, 9'b010_11_1011,
    9'b111_01_0010, 9'b001_10_1111, 9'b110_00_0000
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic addr, input logic [DW-1:0] d);
    busWr = 1; busAddr = addr; busWdata = d;
    @(posedge clk); @(negedge clk);
    busWr = 0;
  endtask

  task automatic regRead(input logic addr, output logic [DW-1:0] d);
    busRd = 1; busAddr = addr;
    #1 d = busRdata;
    @(posedge clk); @(negedge clk);
    busRd = 0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    edges(3);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 dtr/rts pins", {14'd0, dtrOut, rtsOut}, 16'h3);
    check("R1 extIrq", {15'd0, extIrq}, 16'h0);
    regRead(1, rd); check("R1 extin reg", rd, 16'h0);
    regRead(0, rd); check("R1 modem reg", rd, 16'h0);

    // table: R2 pin inversion, R3 readback, R11 loopback
    for (int i = 0; i < 6; i++) begin
      regWrite(0, {13'd0, VEC[i][6], VEC[i][7], VEC[i][8]});
      txSerIn = VEC[i][5]; rxSerIn = VEC[i][4];
      #1;
      check("R2 pins", {14'd0, dtrOut, rtsOut}, {14'd0, VEC[i][3:2]});
      check("R11 serial", {14'd0, txSerOut, rxSerOut}, {14'd0, VEC[i][1:0]});
      regRead(0, rd);
      check("R3 modem readback", rd, {13'd0, VEC[i][6], VEC[i][7], VEC[i][8]});
    end
    regWrite(0, 16'h0);

    // R4 levels, R7 masked edges
    extIrqEn = 1;
    ctsIn = 1; riIn = 1; dsrIn = 1;
    edges(2);
    regRead(1, rd); check("R4 levels", rd, 16'h00D0);
    ctsIn = 0; riIn = 0; dsrIn = 0; dcdIn = 1;
    edges(3);
    check("R7 masked no irq", {15'd0, extIrq}, 16'h0);
    regRead(1, rd); check("R7 masked no flag", rd, 16'h0020);
    dcdIn = 0; edges(3);

    // R3 config readback; masks on, rising-only
    regWrite(1, 16'h0003);
    regRead(1, rd); check("R3 extin cfg readback", rd, 16'h0003);

    // R6 rising-only
    ctsIn = 1; edges(3);
    check("R6 rise irq", {15'd0, extIrq}, 16'h1);
    regRead(1, rd); check("R6 rise flag", rd[9:8], 16'h1);
    regRead(1, rd); check("R8 cleared by read", rd[9:8], 16'h0);
    check("R8 irq low after clear", {15'd0, extIrq}, 16'h0);
    ctsIn = 0; edges(3);
    regRead(1, rd); check("R6 fall ignored", rd[9:8], 16'h0);

    // R5 any-edge
    regWrite(1, 16'h000F);
    dcdIn = 1; edges(3);
    regRead(1, rd); check("R5 dcd rise", rd[9:8], 16'h2);
    dcdIn = 0; edges(3);
    regRead(1, rd); check("R5 dcd fall", rd[9:8], 16'h2);
    ctsIn = 1; edges(3);
    regRead(1, rd); check("R5 cts rise", rd[9:8], 16'h1);
    ctsIn = 0; edges(2);
    check("R5 not before third edge", {15'd0, extIrq}, 16'h0);
    edges(1);
    regRead(1, rd); check("R5 cts fall", rd[9:8], 16'h1);

    // R10 interrupt gating
    dcdIn = 1; edges(3);
    extIrqEn = 0; #1 check("R10 gated off", {15'd0, extIrq}, 16'h0);
    extIrqEn = 1; #1 check("R10 gated on", {15'd0, extIrq}, 16'h1);
    regRead(1, rd);

    // R9 edge coinciding with clearing read
    ctsIn = 1; edges(2);
    regRead(1, rd); check("R9 read shows pre-edge flags", rd[9:8], 16'h0);
    check("R9 irq stays set", {15'd0, extIrq}, 16'h1);
    regRead(1, rd); check("R9 flag survived clear", rd[9:8], 16'h1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule